// File: doc/BRIEF.md
# Three-Mode Latch/Register Bus Driver

This block moves a word from an input bus to a three-state output bus in one of three ways, chosen by its control inputs. With the latch-enable input high, the output follows the input directly. With latch enable low, the block works as a register. It loads the input word when the data-clock input rises, and it keeps its stored word while that clock stays high or stays low. An active-low output enable switches the output drivers on and off. It has no effect on the stored word.

The block lives in one system-clock domain. The data-clock input is sampled on each system clock. A rising edge is a cycle where the sampled value is high and was low on the cycle before. The three-state output is modelled as a data word plus a single drive flag, so surrounding logic or a pad ring can build the real high-impedance driver.

Top module: `bus_mode_driver`

## Requirements
- R1: The input word and the output word are each `DATA_W` bits wide, and `DATA_W` defaults to 18.
- R2: `driveEn` is low in every cycle where `outEnN` is high, and high in every cycle where `outEnN` is low, whatever the other inputs are.
- R3: While `latchEn` is high, `dataOut` equals `dataIn` in the same cycle, with no register in the path.
- R4: While `latchEn` is low, a sampled `dataClk` that is high in a cycle after being low in the cycle before stores `dataIn`. The stored word shows on `dataOut` from the next cycle.
- R5: While `latchEn` is low and `dataClk` shows no rising edge, whether it is held high or held low, `dataOut` keeps its previous value.
- R6: If `dataClk` is high when `latchEn` goes low, `dataOut` keeps the word it showed in the last transparent cycle, until a fresh rising edge arrives.
- R7: When `latchEn` is high in a cycle where `dataClk` rises, transparent mode wins. The word stored is the `dataIn` of that cycle, and no extra capture follows.
- R8: Storage keeps loading and holding as normal while `outEnN` is high. `dataOut` always carries the selected word, whatever the state of `driveEn`.
- R9: A synchronous active-low reset `rstN` clears the stored word to zero. `dataOut` reads zero in the first cycle after release if `latchEn` is low and no edge has been seen yet. `driveEn` still follows `outEnN` during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| dataIn | input | DATA_W | Input word |
| outEnN | input | 1 | Output enable, active low |
| latchEn | input | 1 | High selects transparent mode; low selects register mode |
| dataClk | input | 1 | Data clock, sampled; its rising edge loads the register |
| dataOut | output | DATA_W | Selected word (stored word, or input while transparent) |
| driveEn | output | 1 | High when the output bus should be driven |

## Verification
A wrong stored word only shows at the ports once `latchEn` is low. In register mode it shows on `dataOut` in the very next cycle and stays there until the next rising edge. A transparent period hides it completely. An edge detector that fires spuriously, or fails to fire, changes `dataOut` exactly one cycle after the faulty sample. The bench therefore compares every cycle against a behavioural model. It also places `latchEn` falls on both phases of `dataClk`, so that a missed or extra capture is visible within a cycle.

// File: rtl/bus_mode_driver_pkg.sv
package bus_mode_driver_pkg;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic trackBus;    // transparent: storage follows input, output bypasses
    logic captureBus;  // register mode: load input on detected edge
    logic driveBus;    // output drivers on
  } drvStrobes_t;

endpackage

// File: rtl/bus_mode_driver_ctrl.sv
module bus_mode_driver_ctrl
  import bus_mode_driver_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        outEnN,
  input  logic        latchEn,
  input  logic        dataClk,
  output drvStrobes_t strb
);

  logic clkPrev;
  logic clkRise;

  // Sampled copy of the data clock; follows it even in reset so that
  // release never produces a phantom edge.
  always_ff @(posedge clk) begin
    clkPrev <= dataClk;
  end

  assign clkRise = dataClk & ~clkPrev;

  always_comb begin
    strb.trackBus   = latchEn;
    strb.captureBus = ~latchEn & clkRise;
    strb.driveBus   = ~outEnN;
  end

  // R7
  latch_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> !strb.captureBus);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.trackBus, strb.captureBus}));

  // R4
  capture_needs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureBus |-> (dataClk && !$past(dataClk)));

endmodule

// File: rtl/bus_mode_driver_datapath.sv
module bus_mode_driver_datapath
  import bus_mode_driver_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  drvStrobes_t       strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);

  logic [DATA_W-1:0] heldWord;
  logic              loadNow;

  assign loadNow = strb.trackBus | strb.captureBus;

  always_ff @(posedge clk) begin
    if (!rstN)        heldWord <= '0;
    else if (loadNow) heldWord <= dataIn;
  end

  // Per-bit output select: bypass while transparent, else the stored bit.
  for (genvar b = 0; b < DATA_W; b++) begin : g_outBit
    assign dataOut[b] = strb.trackBus ? dataIn[b] : heldWord[b];
  end

  assign driveEn = strb.driveBus;

  // R4
  capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureBus |=> heldWord == $past(dataIn));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.trackBus && !strb.captureBus) |=> $stable(heldWord));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN) && !strb.trackBus) |-> dataOut == '0);

endmodule

// File: rtl/bus_mode_driver.sv
module bus_mode_driver
  import bus_mode_driver_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  input  logic              latchEn,
  input  logic              dataClk,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);

  drvStrobes_t strb;

  bus_mode_driver_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .outEnN  (outEnN),
    .latchEn (latchEn),
    .dataClk (dataClk),
    .strb    (strb)
  );

  bus_mode_driver_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .strb    (strb),
    .dataOut (dataOut),
    .driveEn (driveEn)
  );

  // R2
  hiz_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !driveEn);

  // R3
  transparent_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> dataOut == dataIn);

  // R6
  fall_while_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(latchEn) && !latchEn && dataClk && $past(rstN)) |-> dataOut == $past(dataIn));

endmodule

// File: tb/bus_mode_driver_bench.sv
`timescale 1ns/1ps
module bus_mode_driver_bench;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         outEnN = 1'b1;
  logic         latchEn = 1'b1;
  logic         dataClk = 1'b0;
  logic [W-1:0] dataOut;
  logic         driveEn;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  logic [W-1:0] mStore = '0;
  logic         mPrev  = 1'b0;

  always #2 clk = ~clk;

  bus_mode_driver #(.DATA_W(W)) u_bus_mode_driver (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .outEnN(outEnN),
    .latchEn(latchEn), .dataClk(dataClk), .dataOut(dataOut), .driveEn(driveEn)
  );

  task automatic tick(input logic rN, input logic le, input logic oeN,
                      input logic dc, input logic [W-1:0] d, input string tag);
    logic [W-1:0] exp;
    rstN = rN; latchEn = le; outEnN = oeN; dataClk = dc; dataIn = d;
    #1;
    checks++;
    if (driveEn !== !oeN) begin
      fails++;
      $display("FAIL %s driveEn: actual %b expected %b", rN ? "R2" : "R9", driveEn, !oeN);
    end
    exp = le ? d : mStore;
    checks++;
    if (dataOut !== exp) begin
      fails++;
      $display("FAIL %s dataOut: actual %h expected %h", tag, dataOut, exp);
    end
    @(posedge clk);
    if (!rN)                mStore = '0;
    else if (le)            mStore = d;
    else if (dc && !mPrev)  mStore = d;
    mPrev = dc;
    @(negedge clk);
  endtask

  initial begin
    #(4.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // reset, transparent so the output is defined
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b1, 1'b0, 18'h0AAAA + W'(i), "R3");
    // R1: width
    checks++;
    if ($bits(dataOut) != 18 || $bits(dataIn) != 18) begin
      fails++;
      $display("FAIL R1 width: actual %0d expected 18", $bits(dataOut));
    end
    // R9: stored word cleared after release
    tick(1'b1, 1'b0, 1'b0, 1'b0, 18'h3FFFF, "R9");
    tick(1'b1, 1'b0, 1'b0, 1'b0, 18'h12345, "R9");
    // R3: transparent, several patterns
    tick(1'b1, 1'b1, 1'b0, 1'b0, 18'h00001, "R3");
    tick(1'b1, 1'b1, 1'b0, 1'b0, 18'h3FFFF, "R3");
    tick(1'b1, 1'b1, 1'b0, 1'b1, 18'h15555, "R3");
    // R6: latch enable falls while data clock high
    tick(1'b1, 1'b0, 1'b0, 1'b1, 18'h2AAAA, "R6");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 18'h0F0F0, "R6");
    // R5: clock low then rising edge; R4 on next cycle
    tick(1'b1, 1'b0, 1'b0, 1'b0, 18'h11111, "R5");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 18'h22222, "R5");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 18'h33333, "R4");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 18'h04444, "R5");
    tick(1'b1, 1'b0, 1'b0, 1'b0, 18'h05555, "R5");
    tick(1'b1, 1'b0, 1'b0, 1'b0, 18'h06666, "R5");
    // R7: edge during transparent mode, then hold with clock high
    tick(1'b1, 1'b1, 1'b0, 1'b1, 18'h1ABCD, "R7");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 18'h2DCBA, "R7");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 18'h00F00, "R7");
    // R8: loading while outputs off
    tick(1'b1, 1'b0, 1'b1, 1'b0, 18'h0BEEF, "R8");
    tick(1'b1, 1'b0, 1'b1, 1'b1, 18'h1CAFE, "R8");
    tick(1'b1, 1'b0, 1'b1, 1'b0, 18'h00000, "R8");
    tick(1'b1, 1'b0, 1'b0, 1'b0, 18'h3F00F, "R8");
    // R9: reset mid-run with outputs on
    tick(1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, "R5");
    tick(1'b1, 1'b0, 1'b0, 1'b0, 18'h3FFFF, "R9");
    // Random mixture
    for (int i = 0; i < 600; i++) begin
      logic le;
      logic dc;
      le = ($urandom_range(0, 3) == 0);
      dc = $urandom_range(0, 1) != 0;
      tick(1'b1, le, $urandom_range(0, 3) == 0, dc, W'($urandom),
           le ? "R3" : "R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule